// File: doc/BRIEF.md
# Periodic Timer With Sticky Event Flags

This block keeps time for a small controller. A divider turns the system clock into a one-cycle enable at a nominal 256 Hz. That enable advances a 7-bit binary counter, so the counter bits toggle at rates from 128 Hz (bit 0) down to 2 Hz (bit 6). Software reaches the block through a 4-bit register bus with three locations:

- **Time value register:** shows the four slowest counter bits.
- **Control register:** holds three interrupt enables and a write-only restart command.
- **Event register:** holds three sticky flags. Each flag is set when a chosen counter bit falls from 1 to 0, and the register clears when it is read.

The interrupt request is high when any flag is set and its enable is on, and the processor's global interrupt enable input is high. Under the default divider the system clock is 32.768 kHz. A build option moves the fastest flag from the 32 Hz bit to the 64 Hz bit.

Top module: `ctm_top`

## Requirements
- R1: The counter advances by exactly one every DIV clock cycles, where DIV is a parameter. After reset or a restart, the first advance comes at the DIV-th rising edge.
- R2: A read of address 0 returns counter bits 3, 4, 5 and 6 on D0, D1, D2 and D3. Those bits are the 16, 8, 4 and 2 Hz taps. A write to address 0 changes nothing. A read of address 3 returns 0.
- R3: Event flag 0 is set when counter bit 2 falls, or bit 1 when FAST_TAP64 is 1. Flag 1 is set when bit 3 falls. Flag 2 is set when bit 6 falls.
- R4: A flag is set whether or not its enable bit is on. Once set, a flag stays set until a read of the event register.
- R5: A read of address 2 returns flag 0, flag 1 and flag 2 on D0, D1 and D2, with D3 = 0. That read then clears all flags.
- R6: If a flag-setting fall happens in the same cycle as an event register read, the flag is set afterwards. The read itself returns the old value.
- R7: Address 1 holds the enables for flag 0, 1 and 2 on D0, D1 and D2. These bits read back as written and are 0 after reset. D3 always reads 0.
- R8: Writing address 1 with D3 = 1 sets the counter and the divider to zero on that edge, and counting goes on from there. A restart never sets a flag. Writing D3 = 0 leaves the count alone.
- R9: irq_out is registered. It goes high one cycle after some flag and its enable are both 1 while cpu_ie is 1, and it is 0 otherwise.
- R10: Read data is registered. It appears on bus_rdata in the cycle after bus_rd, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register address (0 time, 1 control, 2 events) |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data |
| cpu_ie | input | 1 | Global interrupt enable from the processor |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The properties assume the following about the inputs:

- bus_rd and bus_wr are never high in the same cycle.
- Each access lasts exactly one cycle.
- DIV is at least 2, so two enables never fall in adjacent cycles.

The stimulus keeps to these assumptions. It drives every bus access for a single cycle from the falling clock edge. It never overlaps a read with a write. It runs the block with a divider of 16. Reads are placed on chosen edges so that one lands on the exact edge where a flag is set, and a restart is issued while the low counter bits are all ones.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int unsigned CTM_DW    = 4;
  localparam int unsigned CTM_CNT_W = 7;
  localparam int unsigned CTM_NFLAG = 3;

  typedef enum logic [1:0] {
    CTM_A_TIME = 2'd0,
    CTM_A_CTRL = 2'd1,
    CTM_A_EVT  = 2'd2,
    CTM_A_NONE = 2'd3
  } ctm_addr_e;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int unsigned DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr)        pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] fall
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // bit k drops on the next advance when bits k..0 are all ones
  for (genvar k = 0; k < CW; k++) begin : g_fall
    assign fall[k] = tick && !clr && (&cnt_q[k:0]);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ctm_flags.sv
module ctm_flags #(
  parameter int unsigned CW         = 7,
  parameter int unsigned NF         = 3,
  parameter bit          FAST_TAP64 = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fall,
  input  logic          rd_clr,
  output logic [NF-1:0] set_now,
  output logic [NF-1:0] flags
);
  localparam int unsigned TAP0 = FAST_TAP64 ? 1 : 2;
  localparam int unsigned TAP1 = 3;
  localparam int unsigned TAP2 = CW - 1;

  logic [NF-1:0] flag_q;

  if (NF == 3) begin : g_taps
    assign set_now = {fall[TAP2], fall[TAP1], fall[TAP0]};
  end else begin : g_taps_bad
    assign set_now = '0;
  end

  // a new event in the read cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (rd_clr ? '0 : flag_q) | set_now;
  end

  assign flags = flag_q;
endmodule

// File: rtl/ctm_top.sv
module ctm_top
  import ctm_pkg::*;
#(
  parameter int unsigned DIV        = 128,
  parameter bit          FAST_TAP64 = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  input  logic       cpu_ie,
  output logic       irq_out
);
  localparam int unsigned CW = CTM_CNT_W;
  localparam int unsigned NF = CTM_NFLAG;

  logic          tick;
  logic          restart;
  logic          rd_evt;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] fall;
  logic [NF-1:0] flag_set;
  logic [NF-1:0] flag_q;
  logic [NF-1:0] en_q;
  logic [3:0]    rdata_q;
  logic          irq_q;

  assign restart = bus_wr && (bus_addr == CTM_A_CTRL) && bus_wdata[3];
  assign rd_evt  = bus_rd && (bus_addr == CTM_A_EVT);

  ctm_prescaler #(.DIV(DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .tick(tick)
  );

  ctm_counter #(.CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .tick(tick),
    .cnt (cnt_q),
    .fall(fall)
  );

  ctm_flags #(.CW(CW), .NF(NF), .FAST_TAP64(FAST_TAP64)) u_flg (
    .clk    (clk),
    .rst    (rst),
    .fall   (fall),
    .rd_clr (rd_evt),
    .set_now(flag_set),
    .flags  (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (bus_wr && (bus_addr == CTM_A_CTRL)) en_q <= bus_wdata[NF-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        CTM_A_TIME: rdata_q <= cnt_q[CW-1 -: 4];
        CTM_A_CTRL: rdata_q <= {1'b0, en_q};
        CTM_A_EVT:  rdata_q <= {1'b0, flag_q};
        default:    rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cpu_ie && (|(flag_q & en_q));
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/ctm_top_chk.sv
module ctm_top_chk #(
  parameter int unsigned CW = 7,
  parameter int unsigned NF = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [3:0]    bus_wdata,
  input logic [3:0]    bus_rdata,
  input logic          cpu_ie,
  input logic          irq_out,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [NF-1:0] flag_set,
  input logic [NF-1:0] flags
);
  logic restart;
  logic rd_evt;
  assign restart = bus_wr && (bus_addr == 2'd1) && bus_wdata[3];
  assign rd_evt  = bus_rd && (bus_addr == 2'd2);

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> (cnt == $past(cnt) + CW'(1))); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt)); // R1
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0)); // R8
  AST_RESTART_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    restart |-> (flag_set == '0)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rd_evt |=> ((flags & $past(flags)) == $past(flags))); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && (flag_set == '0)) |=> (flags == '0)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R6
  AST_EVT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> !bus_rdata[3]); // R5
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 2'd1)) |=> !bus_rdata[3]); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(cpu_ie)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind ctm_top ctm_top_chk #(.CW(CW), .NF(NF)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cpu_ie   (cpu_ie),
  .irq_out  (irq_out),
  .tick     (tick),
  .cnt      (cnt_q),
  .flag_set (flag_set),
  .flags    (flag_q)
);

// File: tb/ctm_top_tb.sv
module ctm_top_tb;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [3:0] bus_wdata = 4'd0;
  logic       cpu_ie = 1'b0;
  logic [3:0] bus_rdata;
  logic       irq_out;

  ctm_top #(.DIV(DIV), .FAST_TAP64(1'b0)) u_dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ie(cpu_ie), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  // edges since reset or restart, from the bench's own stimulus
  int edges;
  always @(posedge clk) begin
    if (rst || (bus_wr && bus_addr == 2'd1 && bus_wdata[3])) edges <= 0;
    else edges <= edges + 1;
  end

  typedef struct {
    logic [3:0] exp;
    logic [3:0] mask;
    string      tag;
  } item_t;
  item_t q[$];

  int  n_cmp = 0;
  int  n_bad = 0;
  int  cl = 0;
  bit  done = 1'b0;
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare each read result one cycle after its strobe
  always @(negedge clk) begin
    item_t it;
    if (rd_seen) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 unexpected read result act=%h exp=none", bus_rdata);
      end else begin
        it = q.pop_front();
        if (it.mask != 4'h0) begin
          n_cmp++;
          if ((bus_rdata & it.mask) != (it.exp & it.mask)) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [3:0] e,
                    input logic [3:0] m, input string tag);
    item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 4'd0;
  endtask

  task automatic wait_until(input int e);
    while (edges < e) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] time_exp(input int e);
    return 4'(((e / DIV) >> 3) & 15);
  endfunction

  function automatic logic [3:0] evt_exp(input int c0, input int c1);
    logic [3:0] r;
    r[0] = (c1 >> 3) > (c0 >> 3);
    r[1] = (c1 >> 4) > (c0 >> 4);
    r[2] = (c1 >> 7) > (c0 >> 7);
    r[3] = 1'b0;
    return r;
  endfunction

  task automatic rd_evt(input string tag);
    int c;
    c = edges / DIV;
    rd(2'd2, evt_exp(cl, c), 4'hF, tag);
    cl = c;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(irq_out, 1'b0, "R9 irq after reset");
    chk(bus_rdata == 4'h0, 1'b1, "R10 rdata after reset");
    rd(2'd0, 4'h0, 4'hF, "R2 time after reset");
    rd(2'd1, 4'h0, 4'hF, "R7 control after reset");
    rd_evt("R5 events after reset");

    // R1 exact advance edge: value 7 then 8
    wait_until(8 * DIV - 1);
    rd(2'd0, time_exp(edges), 4'hF, "R1 before 8th advance");
    rd(2'd0, time_exp(edges), 4'hF, "R1 at 8th advance");

    // R2 field layout and write ignore
    wait_until(40 * DIV + 5);
    rd(2'd0, time_exp(edges), 4'hF, "R2 time layout");
    wr(2'd0, 4'hF);
    rd(2'd0, time_exp(edges), 4'hF, "R2 write ignored");
    rd(2'd3, 4'h0, 4'hF, "R2 unused address");

    // R3 R4: all three taps, enables off
    cpu_ie = 1'b1;
    wait_until(130 * DIV);
    rd_evt("R3 R4 masked flags set");
    chk(irq_out, 1'b0, "R4 R9 irq masked");

    // R7 enables read back without restart
    wr(2'd1, 4'b0101);
    rd(2'd1, 4'b0101, 4'hF, "R7 enable readback");
    wr(2'd1, 4'b0000);

    // R8 restart while low bits are ones
    wait_until(132 * DIV);
    rd_evt("R8 clear before restart");
    wait_until(135 * DIV + 3);
    wr(2'd1, 4'b1010);
    cl = 0;
    rd_evt("R8 restart sets no flag");
    rd(2'd1, 4'b0010, 4'hF, "R7 restart bit reads 0");
    rd(2'd0, 4'h0, 4'hF, "R8 counter cleared");
    wait_until(8 * DIV - 1);
    rd(2'd0, time_exp(edges), 4'hF, "R1 R8 before 8th advance after restart");
    rd(2'd0, time_exp(edges), 4'hF, "R1 R8 8th advance after restart");

    // R9 irq timing on enabled 16 Hz flag
    wait_until(16 * DIV);
    chk(irq_out, 1'b0, "R9 irq one cycle late");
    @(negedge clk);
    chk(irq_out, 1'b1, "R9 irq raised");
    cpu_ie = 1'b0;
    @(negedge clk);
    chk(irq_out, 1'b0, "R9 irq gated by cpu_ie");
    cpu_ie = 1'b1;
    @(negedge clk);
    chk(irq_out, 1'b1, "R9 irq regated");
    rd_evt("R3 R5 events read and clear");
    @(negedge clk);
    chk(irq_out, 1'b0, "R5 R9 irq drops after clear");

    // R6 read on the exact edge of a 32 Hz fall
    wait_until(24 * DIV - 1);
    rd_evt("R6 read on set edge");
    rd_evt("R6 set survived read");

    wait_until(edges + 4);
    finish_run();
  end
endmodule